// File: doc/BRIEF.md
# Pipelined Microprogram Sequencer

This block is the control section of a microprogrammed processor. It owns a read-only control store of 1024 microwords and a pipeline register on its output. The pipeline register holds the microword that is executing, and its control bits drive the datapath for one clock cycle. During that cycle the sequencer works out the next microaddress and reads that word from the store. The next address comes from one of three places. It can be the current fetch address plus one, the next-address field of the executing microword, or a starting address that an opcode decoder derives from the instruction register. A condition selector picks one status flag or external branch input, and that choice steers conditional jumps.

The fetch address is computed from the word in the pipeline register. A change of flow therefore takes effect one cycle late. The word stored directly after a jump, conditional jump or dispatch always executes; it acts as a delay slot. The control store holds a small test program that is built from the address, so every executing word shows on the outputs which address it came from.

Top module: `usq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `uaddr_o` = 0 and `ctrl_o` = 0, which is the no-operation word.
- R2: The word read from fetch address A at a rising edge appears on `ctrl_o` for the whole following cycle, and `ctrl_o` changes only at rising edges.
- R3: When the executing word is in continue mode, the next fetch address is the current fetch address plus one. IR, flags and branch inputs have no effect on it.
- R4: When the executing word is in jump mode, the next fetch address is its 10-bit next-address field.
- R5: The condition select code picks one of eight conditions: 0 is always true, 1 is flag N (`flags_i[0]`), 2 is Z (`flags_i[1]`), 3 is C (`flags_i[2]`), 4 is V (`flags_i[3]`), and 5 to 7 are `ext_br_i[0]` to `ext_br_i[2]`. A conditional jump is taken when the selected condition XOR the polarity bit is 1. A taken conditional jump loads the next-address field.
- R6: A conditional jump that is not taken continues at the fetch address plus one.
- R7: Dispatch mode loads the address 64 + 4 × opcode, where the opcode is `ir_i[15:12]`.
- R8: A change of flow is delayed by one word. The word that follows a jump, conditional jump or dispatch word in the store executes next. The target word executes in the cycle after that.
- R9: The test program is defined by address a:
  - Every stored word has control bits 0x8000 | a.
  - Address 1 is a dispatch word.
  - For each opcode op, address 64 + 4·op is a conditional jump with select code op[2:0], polarity op[3] and target 32 + 2·op.
  - Addresses 66 + 4·op and 32 + 2·op are jumps to address 1.
  - Every other address is a continue word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ir_i | input | 16 | Instruction register; the top four bits are the opcode |
| flags_i | input | 4 | Status flags N, Z, C, V in bits 0 to 3 |
| ext_br_i | input | 3 | External branch condition inputs |
| ctrl_o | output | 16 | Control bits of the executing microword |
| uaddr_o | output | 10 | Microaddress being fetched this cycle |

## Verification
The bench goes after the one-word delay after every change of flow. A sequencer that takes the branch from the freshly fetched word, instead of from the pipelined one, would skip the delay-slot word and reach the target a cycle early. All sixteen opcodes are driven, with both polarities and every select code, under random and fixed flag patterns. This catches a swapped condition index or an inverted polarity as a wrong target or a wrong fall-through. Inputs change every cycle, so a design that sampled IR or a condition in the wrong cycle would dispatch or branch on stale values. Mid-run resets check that the pipeline returns to the no-operation word and does not keep the word it held before.

// File: rtl/usq_pkg.sv
`timescale 1ns/1ps
package usq_pkg;
    parameter int AW       = 10;
    parameter int CTRL_W   = 16;
    parameter int IR_W     = 16;
    parameter int OP_W     = 4;
    parameter int NFLAG    = 4;
    parameter int NEXT     = 3;
    parameter int MAP_BASE = 64;
    parameter int MAP_SPAN = 4;
    parameter int BR_BASE  = 32;

    localparam int NCOND  = 1 + NFLAG + NEXT;
    localparam int CSEL_W = $clog2(NCOND);
    localparam int NSEL   = 1 << CSEL_W;
    localparam int NOPS   = 1 << OP_W;

    typedef enum logic [1:0] {
        SEQ_CONT = 2'd0,
        SEQ_JUMP = 2'd1,
        SEQ_CJMP = 2'd2,
        SEQ_MAP  = 2'd3
    } seq_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        seq_e              mode;
        logic [CSEL_W-1:0] csel;
        logic              cpol;
        logic [AW-1:0]     target;
    } uword_t;

    localparam uword_t UWORD_NOP = '{ctrl: '0, mode: SEQ_CONT, csel: '0, cpol: 1'b0, target: '0};

    // Test program contents, computed from the address.
    function automatic uword_t rom_word(input logic [AW-1:0] a);
        uword_t w;
        int     ai;
        int     off;
        int     op;
        ai = int'(a);
        w = UWORD_NOP;
        w.ctrl = CTRL_W'(ai) | (CTRL_W'(1) << (CTRL_W - 1));
        if (ai == 1) begin
            w.mode = SEQ_MAP;
        end else if (ai >= MAP_BASE && ai < MAP_BASE + MAP_SPAN * NOPS) begin
            off = (ai - MAP_BASE) % MAP_SPAN;
            op  = (ai - MAP_BASE) / MAP_SPAN;
            if (off == 0) begin
                w.mode   = SEQ_CJMP;
                w.csel   = CSEL_W'(op & (NSEL - 1));
                w.cpol   = ((op >> CSEL_W) & 1) != 0;
                w.target = AW'(BR_BASE + 2 * op);
            end else if (off == 2) begin
                w.mode   = SEQ_JUMP;
                w.target = AW'(1);
            end
        end else if (ai >= BR_BASE && ai < BR_BASE + 2 * NOPS && ((ai - BR_BASE) % 2) == 0) begin
            w.mode   = SEQ_JUMP;
            w.target = AW'(1);
        end
        return w;
    endfunction
endpackage

// File: rtl/usq_decode_map.sv
`timescale 1ns/1ps
module usq_decode_map
    import usq_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    output logic [AW-1:0]   start
);
    logic [OP_W-1:0] opcode;

    assign opcode = ir[IR_W-1 -: OP_W];

    always_comb begin
        start = AW'(MAP_BASE + MAP_SPAN * int'(opcode));
    end
endmodule

// File: rtl/usq_cond_mux.sv
`timescale 1ns/1ps
module usq_cond_mux
    import usq_pkg::*;
(
    input  logic [NFLAG-1:0]  flags,
    input  logic [NEXT-1:0]   ext_br,
    input  logic [CSEL_W-1:0] csel,
    input  logic              cpol,
    output logic              take
);
    logic [NSEL-1:0] cv;

    for (genvar k = 0; k < NSEL; k++) begin : g_cond
        if (k == 0) begin : g_true
            assign cv[k] = 1'b1;
        end else if (k <= NFLAG) begin : g_flag
            assign cv[k] = flags[k-1];
        end else if (k < NCOND) begin : g_ext
            assign cv[k] = ext_br[k-1-NFLAG];
        end else begin : g_pad
            assign cv[k] = 1'b0;
        end
    end

    assign take = cv[csel] ^ cpol;
endmodule

// File: rtl/usq_next_addr.sv
`timescale 1ns/1ps
module usq_next_addr
    import usq_pkg::*;
(
    input  seq_e          mode,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] fa,
    input  logic          take,
    input  logic [AW-1:0] map_start,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] inc;

    assign inc = fa + AW'(1);

    always_comb begin
        unique case (mode)
            SEQ_JUMP: nxt = target;
            SEQ_CJMP: nxt = take ? target : inc;
            SEQ_MAP:  nxt = map_start;
            default:  nxt = inc;
        endcase
    end
endmodule

// File: rtl/usq_ctrl_store.sv
`timescale 1ns/1ps
module usq_ctrl_store
    import usq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] fa,
    output uword_t        pipe_q
);
    uword_t rd;

    always_comb begin
        rd = rom_word(fa);
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= UWORD_NOP;
        else     pipe_q <= rd;
    end

    // Executing word carries the address it was fetched from.
    assert_pipe_latency_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pipe_q.ctrl[AW-1:0] == $past(fa));
endmodule

// File: rtl/usq_sequencer.sv
`timescale 1ns/1ps
module usq_sequencer
    import usq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir_i,
    input  logic [NFLAG-1:0]  flags_i,
    input  logic [NEXT-1:0]   ext_br_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [AW-1:0]     uaddr_o
);
    logic [AW-1:0] fa;
    logic [AW-1:0] fa_nxt;
    logic [AW-1:0] map_start;
    logic          take;
    uword_t        pipe_q;

    usq_ctrl_store u_store (
        .clk    (clk),
        .rst    (rst),
        .fa     (fa),
        .pipe_q (pipe_q)
    );

    usq_decode_map u_map (
        .ir    (ir_i),
        .start (map_start)
    );

    usq_cond_mux u_cond (
        .flags  (flags_i),
        .ext_br (ext_br_i),
        .csel   (pipe_q.csel),
        .cpol   (pipe_q.cpol),
        .take   (take)
    );

    usq_next_addr u_next (
        .mode      (pipe_q.mode),
        .target    (pipe_q.target),
        .fa        (fa),
        .take      (take),
        .map_start (map_start),
        .nxt       (fa_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) fa <= '0;
        else     fa <= fa_nxt;
    end

    assign ctrl_o  = pipe_q.ctrl;
    assign uaddr_o = fa;

    assert_reset_nop_R1: assert property (@(posedge clk)
        rst |=> (uaddr_o == '0 && ctrl_o == '0));

    assert_continue_R3: assert property (@(posedge clk) disable iff (rst)
        pipe_q.mode == SEQ_CONT |=> fa == $past(fa) + AW'(1));

    assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
        pipe_q.mode == SEQ_JUMP |=> fa == $past(pipe_q.target));

    assert_cjmp_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (pipe_q.mode == SEQ_CJMP && take) |=> fa == $past(pipe_q.target));

    assert_cjmp_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (pipe_q.mode == SEQ_CJMP && !take) |=> fa == $past(fa) + AW'(1));

    assert_map_range_R7: assert property (@(posedge clk) disable iff (rst)
        pipe_q.mode == SEQ_MAP |=> (fa >= AW'(MAP_BASE)
            && ((fa - AW'(MAP_BASE)) % AW'(MAP_SPAN)) == '0));
endmodule

// File: tb/sim_usq_sequencer.sv
`timescale 1ns/1ps
module sim_usq_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ir_i = '0;
    logic [3:0]  flags_i = '0;
    logic [2:0]  ext_br_i = '0;
    logic [15:0] ctrl_o;
    logic [9:0]  uaddr_o;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 0;
    int    m_fa;
    int    m_pa;
    string ua_tag;
    string ct_tag;

    usq_sequencer u0 (
        .clk      (clk),
        .rst      (rst),
        .ir_i     (ir_i),
        .flags_i  (flags_i),
        .ext_br_i (ext_br_i),
        .ctrl_o   (ctrl_o),
        .uaddr_o  (uaddr_o)
    );

    always #2.5 clk = ~clk;

    // Mode codes for the bench: 0 continue, 1 jump, 2 conditional, 3 dispatch (R9 program)
    function automatic int p_mode(int a);
        if (a < 0) return 0;
        if (a == 1) return 3;
        if (a >= 64 && a < 128) begin
            if ((a - 64) % 4 == 0) return 2;
            if ((a - 64) % 4 == 2) return 1;
            return 0;
        end
        if (a >= 32 && a < 64 && (a % 2) == 0) return 1;
        return 0;
    endfunction

    function automatic int p_target(int a);
        if (p_mode(a) == 2) return 32 + 2 * ((a - 64) / 4);
        return 1;
    endfunction

    function automatic bit p_take(int a, logic [3:0] f, logic [2:0] e);
        int op;
        int sel;
        bit c;
        op  = (a - 64) / 4;
        sel = op & 7;
        if (sel == 0)      c = 1'b1;
        else if (sel <= 4) c = f[sel-1];
        else               c = e[sel-5];
        return c ^ ((op >> 3) & 1);
    endfunction

    function automatic logic [15:0] exp_ctrl(int a);
        if (a < 0) return 16'h0000;
        return 16'h8000 | 16'(a);
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a negedge after inputs for the coming edge are driven.
    task automatic advance();
        int md;
        int nf;
        md = p_mode(m_pa);
        ct_tag = (md != 0) ? "R8" : "R2";
        case (md)
            1: begin nf = p_target(m_pa); ua_tag = "R4"; end
            2: begin
                if (p_take(m_pa, flags_i, ext_br_i)) begin nf = p_target(m_pa); ua_tag = "R5"; end
                else begin nf = (m_fa + 1) % 1024; ua_tag = "R6"; end
            end
            3: begin nf = 64 + 4 * int'(ir_i[15:12]); ua_tag = "R7"; end
            default: begin nf = (m_fa + 1) % 1024; ua_tag = "R3"; end
        endcase
        m_pa = m_fa;
        m_fa = nf;
    endtask

    task automatic step_check();
        // ctrl tag: R8 marks the delay-slot word following a branch; R2/R9 otherwise
        check(ct_tag, int'(ctrl_o), int'(exp_ctrl(m_pa)));
        check(ua_tag, int'(uaddr_o), m_fa);
    endtask

    task automatic do_reset(int cycles);
        rst = 1'b1;
        repeat (cycles) @(negedge clk);
        check("R1", int'(ctrl_o), 0);
        check("R1", int'(uaddr_o), 0);
        m_fa = 0;
        m_pa = -1;
        ua_tag = "R3";
        ct_tag = "R2";
        rst = 1'b0;
    endtask

    task automatic run(int n, bit rnd, logic [3:0] op, logic [3:0] f, logic [2:0] e);
        for (int i = 0; i < n; i++) begin
            if (rnd) begin
                ir_i     = 16'($urandom);
                flags_i  = 4'($urandom);
                ext_br_i = 3'($urandom);
            end else begin
                ir_i     = {op, 12'($urandom)};
                flags_i  = f;
                ext_br_i = e;
            end
            advance();
            @(negedge clk);
            step_check();
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        do_reset(2);
        // Directed: always-taken (op 0) and never-taken (op 8) show the delay slot (R8, R5, R6)
        run(40, 1'b0, 4'd0, 4'h0, 3'h0);
        run(40, 1'b0, 4'd8, 4'h0, 3'h0);
        // Every select code with conditions all high and all low, both polarities (R5, R6, R7)
        for (int op = 0; op < 16; op++) begin
            run(24, 1'b0, 4'(op), 4'hF, 3'h7);
            run(24, 1'b0, 4'(op), 4'h0, 3'h0);
        end
        do_reset(1);
        // Random inputs changing every cycle (R3 inputs ignored in continue mode)
        run(3000, 1'b1, 4'd0, 4'h0, 3'h0);
        do_reset(3);
        run(1000, 1'b1, 4'd0, 4'h0, 3'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule